// File: doc/BRIEF.md
# Stop-State Wake Controller

This block decides when a halted core may start executing again. While the core runs, a pulse on `stop_req` parks it in a stop state and drops `run_enable`. A small configuration register picks one wake source: one of three separate single pins, a single pin of the 8-bit general port, or a NOR over the lower four or all eight bits of that port. Two settings never wake the core, and in those only the external reset brings it back. A polarity bit chooses whether a high or a low level on the source counts as active. Port bits that are currently driven as outputs are masked to 0 before any term is formed.

On a wake, the block can run a stabilisation count of `DLY_CYC` cycles before it raises `run_enable`. It can instead take a fast wake, which is accepted only after the source has stayed active for `QUAL_CYC` consecutive cycles. A read-only flag in the read word tells software whether the last restart came from a stop wake (warm) or from a reset (cold). Every pin is passed through a two-flop synchroniser on `clk`, which keeps running while the core is stopped.

Top module: `stop_wake_ctrl`

## Requirements
- R1: After power-on reset (`rst_n` low), `rd_data` reads 6'b010000 (select 000, polarity 0, delay-select 1, warm flag 0). `run_enable` stays low for `DLY_CYC` cycles after reset release and then rises.
- R2: Field layout: `rd_data[2:0]` is the select, `[3]` the polarity, `[4]` the delay-select and `[5]` the warm flag. A cycle with `wr_en` high loads `wr_data[4:0]` into select, polarity and delay-select. `wr_data[5]` has no effect on the warm flag.
- R3: `stop_req` high while `run_enable` is high drops `run_enable` in the next cycle. The block is then in the stop state. `stop_req` has no effect while `run_enable` is low.
- R4: With select 000 or 001, no pin activity leaves the stop state. Only `ext_rst` does.
- R5: Select 010, 011 and 100 use `p3_pin[0]`, `p3_pin[1]` and `p3_pin[2]`. Select 101 uses `p2_pin[7]`, which is forced to 0 while `p2_dir_out[7]` is 1.
- R6: Select 110 uses the NOR of `p2_pin[3:0]` and select 111 uses the NOR of `p2_pin[7:0]`. Any bit whose `p2_dir_out` bit is 1 enters the NOR as 0.
- R7: With polarity 1, a high level on the selected source is active. With polarity 0, a low level is active. Pins reach the wake logic through two synchronising flops.
- R8: With delay-select 1, one active cycle in the stop state starts the wake. `run_enable` rises after `DLY_CYC` further cycles.
- R9: With delay-select 0, the source must be active for `QUAL_CYC` consecutive cycles. `run_enable` rises on the cycle after the last of them. A shorter burst of activity does not wake the core.
- R10: The warm flag becomes 1 when a stop wake is accepted. It is cleared by `rst_n` or `ext_rst`, and it is otherwise stable.
- R11: A cycle with `ext_rst` high (synchronous to `clk`) clears the warm flag and starts the `DLY_CYC` delay from any state. The configuration is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running wake clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst | input | 1 | Synchronous external reset, active high |
| stop_req | input | 1 | Enter the stop state (honoured while running) |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | 6 | Write word (bit 5 ignored) |
| rd_data | output | 6 | {warm, delay-select, polarity, select} |
| p3_pin | input | 3 | Single-pin wake inputs |
| p2_pin | input | 8 | General port inputs |
| p2_dir_out | input | 8 | Per-bit 1 = port bit is an output (masked) |
| run_enable | output | 1 | High while the core may execute |

## Verification
A wrong select decode, mask or polarity shows up as `run_enable` rising in a stop period that should never end, or staying low when it should rise. This appears within the two synchroniser cycles plus the qualification or delay window. Off-by-one errors in the delay or qualification counters move the rising edge of `run_enable` by one cycle. The bench compares that edge with its model on every clock. A wrong warm flag or a corrupted configuration field is visible at once on `rd_data`, which is also compared every cycle.

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl #(
  parameter int DLY_CYC  = 1024,
  parameter int QUAL_CYC = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_rst,
  input  logic       stop_req,
  input  logic       wr_en,
  input  logic [5:0] wr_data,
  output logic [5:0] rd_data,
  input  logic [2:0] p3_pin,
  input  logic [7:0] p2_pin,
  input  logic [7:0] p2_dir_out,
  output logic       run_enable
);
  localparam int CW = (DLY_CYC > 2) ? $clog2(DLY_CYC) : 1;
  localparam int QW = (QUAL_CYC > 2) ? $clog2(QUAL_CYC) : 1;
  localparam logic [CW-1:0] LOAD  = CW'(DLY_CYC - 1);
  localparam logic [QW-1:0] QLAST = QW'(QUAL_CYC - 1);

  localparam logic [1:0] S_RUN  = 2'd0;
  localparam logic [1:0] S_STOP = 2'd1;
  localparam logic [1:0] S_DLY  = 2'd2;

  logic [10:0]   sy1, sy2;
  logic [2:0]    sel;
  logic          pol, dly, warm;
  logic [1:0]    st;
  logic [CW-1:0] cnt;
  logic [QW-1:0] q;
  logic          src, hit, dly_done;
  logic [7:0]    p2m;
  logic [2:0]    p3s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
    end else begin
      sy1 <= {p3_pin, p2_pin};
      sy2 <= sy1;
    end

  assign p3s = sy2[10:8];
  assign p2m = sy2[7:0] & ~p2_dir_out;

  always_comb
    case (sel)
      3'd2:    src = p3s[0];
      3'd3:    src = p3s[1];
      3'd4:    src = p3s[2];
      3'd5:    src = p2m[7];
      3'd6:    src = ~|p2m[3:0];
      3'd7:    src = ~|p2m;
      default: src = 1'b0;
    endcase

  assign hit        = (sel[2] | sel[1]) & (src == pol);
  assign dly_done   = (cnt == '0);
  assign run_enable = (st == S_RUN);
  assign rd_data    = {warm, dly, pol, sel};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel  <= 3'd0;
      pol  <= 1'b0;
      dly  <= 1'b1;
      warm <= 1'b0;
      st   <= S_DLY;
      cnt  <= LOAD;
      q    <= '0;
    end else begin
      if (wr_en) {dly, pol, sel} <= wr_data[4:0];
      if (ext_rst) begin
        st   <= S_DLY;
        cnt  <= LOAD;
        warm <= 1'b0;
        q    <= '0;
      end else begin
        case (st)
          S_RUN:
            if (stop_req) begin
              st <= S_STOP;
              q  <= '0;
            end
          S_STOP:
            if (!hit) q <= '0;
            else if (dly) begin
              st   <= S_DLY;
              cnt  <= LOAD;
              warm <= 1'b1;
            end else if (q == QLAST) begin
              st   <= S_RUN;
              warm <= 1'b1;
            end else q <= q + 1'b1;
          default:
            if (dly_done) st <= S_RUN;
            else cnt <= cnt - 1'b1;
        endcase
      end
    end
endmodule

module stop_wake_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ext_rst,
  input logic       stop_req,
  input logic       wr_en,
  input logic [5:0] wr_data,
  input logic [5:0] rd_data,
  input logic       run_enable,
  input logic [1:0] st,
  input logic       dly_done
);
  AST_STOP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (run_enable && stop_req && !ext_rst) |=> !run_enable); // R3
  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[4:0] == $past(wr_data[4:0]))); // R2
  AST_NO_WAKE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && rd_data[2:1] == 2'b00 && !ext_rst) |=> (st == 2'd1)); // R4
  AST_EXT_CLEARS_WARM: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rst |=> (!rd_data[5] && !run_enable)); // R11
  AST_WARM_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_rst && st != 2'd1) |=> $stable(rd_data[5])); // R10
  AST_DELAY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && !dly_done && !ext_rst) |=> !run_enable); // R8
endmodule

bind stop_wake_ctrl stop_wake_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .stop_req(stop_req),
  .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .run_enable(run_enable), .st(st), .dly_done(dly_done)
);

// File: tb/test_stop_wake_ctrl.sv
module test_stop_wake_ctrl;
  localparam int DLY = 24;
  localparam int QUAL = 10;

  logic clk = 0, rst_n = 0, ext_rst = 0, stop_req = 0, wr_en = 0;
  logic [5:0] wr_data = 0;
  logic [5:0] rd_data;
  logic [2:0] p3_pin = 0;
  logic [7:0] p2_pin = 0, p2_dir_out = 0;
  logic run_enable;

  stop_wake_ctrl #(.DLY_CYC(DLY), .QUAL_CYC(QUAL)) i_stop_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .stop_req(stop_req),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .p3_pin(p3_pin), .p2_pin(p2_pin), .p2_dir_out(p2_dir_out),
    .run_enable(run_enable)
  );

  always #5 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  string tag = "R1";

  // behavioural reference
  int m_mode, m_left, m_streak;
  bit [2:0] m_sel;
  bit m_pol, m_dly, m_warm;
  bit [10:0] h1, h2;

  function automatic bit wakes(bit [2:0] s, bit pl, bit [10:0] h, bit [7:0] dir);
    bit [7:0] v;
    bit lvl;
    v = h[7:0] & ~dir;
    if (s < 2) return 0;
    if (s == 2) lvl = h[8];
    else if (s == 3) lvl = h[9];
    else if (s == 4) lvl = h[10];
    else if (s == 5) lvl = v[7];
    else if (s == 6) lvl = (v[3:0] == 0);
    else lvl = (v == 0);
    return lvl == pl;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 2; m_left = DLY; m_streak = 0;
      m_sel = 0; m_pol = 0; m_dly = 1; m_warm = 0; h1 = 0; h2 = 0;
    end else begin
      bit w;
      w = wakes(m_sel, m_pol, h2, p2_dir_out);
      if (ext_rst) begin
        m_mode = 2; m_left = DLY; m_warm = 0;
      end else if (m_mode == 0) begin
        if (stop_req) begin m_mode = 1; m_streak = 0; end
      end else if (m_mode == 1) begin
        if (!w) m_streak = 0;
        else if (m_dly) begin m_mode = 2; m_left = DLY; m_warm = 1; end
        else begin
          m_streak++;
          if (m_streak == QUAL) begin m_mode = 0; m_warm = 1; end
        end
      end else begin
        m_left--;
        if (m_left == 0) m_mode = 0;
      end
      if (wr_en) {m_dly, m_pol, m_sel} = wr_data[4:0];
      h2 = h1; h1 = {p3_pin, p2_pin};
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(tag, {7'd0, run_enable}, {7'd0, m_mode == 0});
    chk(tag, {2'd0, rd_data}, {2'd0, m_warm, m_dly, m_pol, m_sel});
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(logic [5:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic go_stop;
    @(negedge clk); stop_req = 1;
    @(negedge clk); stop_req = 0;
  endtask
  task automatic xrst;
    @(negedge clk); ext_rst = 1;
    @(negedge clk); ext_rst = 0;
    cycles(DLY + 2);
  endtask

  initial begin
    cycles(3);
    chk("R1", {2'd0, rd_data}, 8'h10);
    chk("R1", {7'd0, run_enable}, 8'h0);
    rst_n = 1;
    cycles(DLY - 2);
    chk("R1", {7'd0, run_enable}, 8'h0);
    cycles(4);
    chk("R1", {7'd0, run_enable}, 8'h1);

    tag = "R2";
    wr(6'b111111);
    chk("R2", {2'd0, rd_data}, 8'h1f);
    tag = "R3";
    @(negedge clk); stop_req = 1;
    @(negedge clk); stop_req = 0;
    chk("R3", {7'd0, run_enable}, 8'h0);

    tag = "R11";
    xrst;
    chk("R11", {2'd0, rd_data}, 8'h1f);

    tag = "R8";
    wr(6'b011010);
    go_stop; cycles(10);
    chk("R8", {7'd0, run_enable}, 8'h0);
    p3_pin[0] = 1; cycles(DLY + 6);
    chk("R8", {7'd0, run_enable}, 8'h1);
    chk("R10", {7'd0, rd_data[5]}, 8'h1);
    tag = "R10";
    xrst;
    chk("R10", {7'd0, rd_data[5]}, 8'h0);

    tag = "R9";
    p3_pin = 3'b010;
    wr(6'b000011);
    go_stop; cycles(4);
    p3_pin[1] = 0; cycles(QUAL - 3); p3_pin[1] = 1; cycles(8);
    chk("R9", {7'd0, run_enable}, 8'h0);
    p3_pin[1] = 0; cycles(QUAL + 4);
    chk("R9", {7'd0, run_enable}, 8'h1);

    tag = "R5";
    p3_pin = 0;
    wr(6'b001100);
    go_stop; cycles(6);
    p3_pin[2] = 1; cycles(QUAL + 4);
    chk("R5", {7'd0, run_enable}, 8'h1);
    p2_dir_out = 8'h80; p2_pin = 8'hff;
    wr(6'b001101);
    go_stop; cycles(20);
    chk("R5", {7'd0, run_enable}, 8'h0);
    p2_dir_out = 0; cycles(QUAL + 4);
    chk("R5", {7'd0, run_enable}, 8'h1);

    tag = "R7";
    p2_pin = 8'h00;
    wr(6'b000101);
    go_stop; cycles(QUAL + 4);
    chk("R7", {7'd0, run_enable}, 8'h1);

    tag = "R6";
    p2_pin = 8'h01;
    wr(6'b001110);
    go_stop; cycles(15);
    chk("R6", {7'd0, run_enable}, 8'h0);
    p2_dir_out = 8'h01; cycles(QUAL + 4);
    chk("R6", {7'd0, run_enable}, 8'h1);
    p2_dir_out = 0; p2_pin = 8'h80;
    wr(6'b001111);
    go_stop; cycles(15);
    chk("R6", {7'd0, run_enable}, 8'h0);
    p2_dir_out = 8'h80; cycles(QUAL + 4);
    chk("R6", {7'd0, run_enable}, 8'h1);
    p2_dir_out = 0; p2_pin = 8'h00;

    tag = "R4";
    wr(6'b001000);
    go_stop;
    for (int i = 0; i < 40; i++) begin
      p3_pin = 3'(i); p2_pin = 8'(i * 37); cycles(1);
    end
    chk("R4", {7'd0, run_enable}, 8'h0);
    wr(6'b011001);
    for (int i = 0; i < 40; i++) begin
      p3_pin = 3'(i + 3); p2_pin = 8'(i * 91); cycles(1);
    end
    chk("R4", {7'd0, run_enable}, 8'h0);
    xrst;
    chk("R4", {7'd0, run_enable}, 8'h1);

    cycles(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule